// File: doc/BRIEF.md
# Round-Robin Record Arbiter

This block merges a fixed group of record sources onto one output stream. Each source holds whole records in its own buffer and raises a per-source ready flag while at least one complete record is waiting. A scan pointer walks the sources in a ring. When the pointer lands on a ready source, the arbiter grants it and reads one complete record of `REC_LEN` words from it, one word per cycle. The record is never cut short and never interleaved with another source. The search then restarts at the source after the one just served, so every source gets a fair turn.

The control is a two-state machine. In **SCAN** the pointer looks at one source per cycle. **SCAN→DRAIN** is taken when the source under the pointer is ready; that source is latched as the grant. **SCAN→SCAN** moves the pointer on by one, wrapping from the last source to source 0. **DRAIN→DRAIN** reads the next word of the granted source. **DRAIN→SCAN** is taken on the last word of the record and reloads the pointer with the grant plus one, modulo the source count. Sources are read with show-ahead semantics: the word a source presents in the cycle its read enable is high is the word consumed. Each output word appears one cycle later, with a start marker on the first word and an end marker on the last. Output groups are built by instantiating one arbiter per block of consecutive channels, for example channels 0–9 on output 0 and 10–19 on output 1.

Top module: `rr_record_arbiter`

## Requirements
- R1: During reset and in the first cycle after it, `out_valid` and every `src_rd` bit are 0. The pointer starts at source 0, so if all sources are ready when reset is released, source 0 is served first.
- R2: At most one bit of `src_rd` is high in any cycle.
- R3: A read enable is only given to a source that raised `src_ready` in the scan cycle that granted it.
- R4: A grant reads exactly `REC_LEN` words from one source in consecutive cycles. The matching `out_valid` run has no gaps, and the number of records output equals the number of records offered.
- R5: `out_data` in a valid cycle equals the word the granted source presented in the previous cycle. The bench encodes the source number in bits [15:8] and the word index in bits [7:0].
- R6: `out_sop` is high only on word index 0 of a record and `out_eop` only on word index `REC_LEN-1`. Both are only ever high together with `out_valid`.
- R7: After serving source k, the next record comes from the first ready source in the order k+1, k+2, … modulo `NUM_SRC`, and source `NUM_SRC-1` is followed by source 0.
- R8: The scan advances one source per cycle. Between two back-to-back records, the next `out_sop` comes d+2 cycles after the previous `out_eop`, where d is the number of non-ready sources skipped. From an idle arbiter, a newly ready source produces `out_sop` between 2 and `NUM_SRC+1` cycles after it becomes ready.
- R9: A granted record is not preempted. Dropping the granted source's `src_ready` mid-record, or raising other sources' flags, does not shorten, pause or redirect the record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_ready | input | NUM_SRC | Per-source flag: a complete record is waiting |
| src_rd | output | NUM_SRC | Per-source read enable, one word per cycle |
| src_data | input | NUM_SRC*DATA_W | Show-ahead data of every source, source i at bits [i*DATA_W +: DATA_W] |
| out_valid | output | 1 | Output word valid |
| out_data | output | DATA_W | Output word |
| out_sop | output | 1 | First word of a record |
| out_eop | output | 1 | Last word of a record |

## Verification
The critical coincidence is the last read of one record falling in the same cycle as the pointer reload that starts the next search, while other sources already hold ready records. This is provoked by offering records to all ten sources at once, by giving one source two records alongside sparse neighbours, and by adding new records while a drain is under way. The bench judges each case on the order in which sources appear and on the exact gap from each end marker to the next start marker. A second coincidence, the granted source dropping its ready flag in the middle of its own drain, is provoked directly. It is judged on the record still arriving complete and contiguous.

// File: rtl/rra_pkg.sv
`timescale 1ns/1ps
package rra_pkg;
    typedef enum logic [0:0] {
        ST_SCAN  = 1'b0,
        ST_DRAIN = 1'b1
    } arb_state_t;
endpackage

// File: rtl/rra_scan_ptr.sv
`timescale 1ns/1ps
// Ring pointer over the sources: steps by one, or jumps to one past a given index.
module rra_scan_ptr #(
    parameter int NUM_SRC = 10,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             load,
    input  logic [IDX_W-1:0] load_idx,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SRC - 1);

    function automatic logic [IDX_W-1:0] ring_inc(input logic [IDX_W-1:0] v);
        return (v == LAST_IDX) ? '0 : v + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= ring_inc(load_idx);
        end else if (advance) begin
            ptr <= ring_inc(ptr);
        end
    end

    a_r7_ptr_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= LAST_IDX);
    a_r8_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        advance && !load && ptr != LAST_IDX |=> ptr == $past(ptr) + 1'b1);
endmodule

// File: rtl/rra_word_counter.sv
`timescale 1ns/1ps
// Counts the words of the record in flight and flags the first and last.
module rra_word_counter #(
    parameter int REC_LEN = 1025,
    localparam int CNT_W  = (REC_LEN > 1) ? $clog2(REC_LEN) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic first,
    output logic last
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(REC_LEN - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= (cnt_q == LAST_CNT) ? '0 : cnt_q + 1'b1;
        end
    end

    assign first = (cnt_q == '0);
    assign last  = (cnt_q == LAST_CNT);

    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_CNT);
    a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt_q));
endmodule

// File: rtl/rra_out_stage.sv
`timescale 1ns/1ps
// Registered output: selects the granted source's word and tags the record edges.
module rra_out_stage #(
    parameter int NUM_SRC = 10,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_any,
    input  logic [IDX_W-1:0]          sel,
    input  logic                      word_first,
    input  logic                      word_last,
    input  logic [NUM_SRC*DATA_W-1:0] src_data,
    output logic                      out_valid,
    output logic [DATA_W-1:0]         out_data,
    output logic                      out_sop,
    output logic                      out_eop
);
    logic [DATA_W-1:0] picked;
    assign picked = src_data[sel*DATA_W +: DATA_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= rd_any;
            out_sop   <= rd_any && word_first;
            out_eop   <= rd_any && word_last;
            if (rd_any) begin
                out_data <= picked;
            end
        end
    end

    a_r6_sop_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_sop |-> out_valid);
    a_r6_eop_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_eop |-> out_valid);
    a_r4_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_eop |=> out_valid && !out_sop);
endmodule

// File: rtl/rr_record_arbiter.sv
`timescale 1ns/1ps
// Record-granular round-robin arbiter: one whole record per grant, ring-ordered search.
module rr_record_arbiter #(
    parameter int NUM_SRC = 10,
    parameter int DATA_W  = 32,
    parameter int REC_LEN = 1025
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        src_ready,
    output logic [NUM_SRC-1:0]        src_rd,
    input  logic [NUM_SRC*DATA_W-1:0] src_data,
    output logic                      out_valid,
    output logic [DATA_W-1:0]         out_data,
    output logic                      out_sop,
    output logic                      out_eop
);
    import rra_pkg::*;

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    arb_state_t       state_q, state_d;
    logic [IDX_W-1:0] grant_q, grant_d;
    logic [IDX_W-1:0] scan_ptr;
    logic             ptr_adv, ptr_load;
    logic             word_first, word_last;
    logic             draining;

    rra_scan_ptr #(.NUM_SRC(NUM_SRC)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (ptr_adv),
        .load     (ptr_load),
        .load_idx (grant_q),
        .ptr      (scan_ptr)
    );

    rra_word_counter #(.REC_LEN(REC_LEN)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (draining),
        .first (word_first),
        .last  (word_last)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SCAN;
            grant_q <= '0;
        end else begin
            state_q <= state_d;
            grant_q <= grant_d;
        end
    end

    // Next state and pointer control
    always_comb begin
        state_d  = state_q;
        grant_d  = grant_q;
        ptr_adv  = 1'b0;
        ptr_load = 1'b0;
        unique case (state_q)
            ST_SCAN: begin
                if (src_ready[scan_ptr]) begin
                    state_d = ST_DRAIN;
                    grant_d = scan_ptr;
                end else begin
                    ptr_adv = 1'b1;
                end
            end
            ST_DRAIN: begin
                if (word_last) begin
                    state_d  = ST_SCAN;
                    ptr_load = 1'b1;
                end
            end
            default: state_d = ST_SCAN;
        endcase
    end

    // Outputs: read enable to the granted source only while draining
    assign draining = (state_q == ST_DRAIN);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_rd
        assign src_rd[g] = draining && (grant_q == IDX_W'(g));
    end

    rra_out_stage #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_any     (draining),
        .sel        (grant_q),
        .word_first (word_first),
        .word_last  (word_last),
        .src_data   (src_data),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_sop    (out_sop),
        .out_eop    (out_eop)
    );

    a_r2_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_rd));
    a_r3_grant_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (src_rd != '0) && ($past(src_rd) == '0) |-> (($past(src_ready) & src_rd) != '0));
    a_r9_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
        draining && !word_last |=> draining && $stable(grant_q));
    a_r5_out_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        (src_rd != '0) |=> out_valid);
endmodule

// File: tb/test_rr_record_arbiter.sv
`timescale 1ns/1ps
module test_rr_record_arbiter;
    localparam int N = 10;
    localparam int W = 16;
    localparam int L = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [N-1:0]     src_ready;
    logic [N-1:0]     src_rd;
    logic [N*W-1:0]   src_data;
    logic             out_valid;
    logic [W-1:0]     out_data;
    logic             out_sop;
    logic             out_eop;

    always #2.5 clk = ~clk;

    rr_record_arbiter #(.NUM_SRC(N), .DATA_W(W), .REC_LEN(L)) i_rr_record_arbiter (
        .clk(clk), .rst_n(rst_n), .src_ready(src_ready), .src_rd(src_rd),
        .src_data(src_data), .out_valid(out_valid), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop)
    );

    // Source model state
    int           pending [N];
    int           widx    [N];
    bit           hide    [N];
    logic [N-1:0] rd_prev;

    always @* begin
        for (int s = 0; s < N; s++) begin
            src_ready[s]       = (pending[s] > 0) && !hide[s];
            src_data[s*W +: W] = {8'(s), 8'(widx[s])};
        end
    end

    int checks = 0, failures = 0;
    int cyc = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor state
    bit in_rec = 0, chain = 0, fresh = 0, lat_armed = 0;
    int cur_src = 0, exp_idx = 0, last_served = 0, eop_cyc = 0, inject_cyc = 0;
    int served_total = 0, injected_total = 0;

    function automatic int rr_next(input int last);
        for (int k = 1; k <= N; k++) begin
            if (pending[(last + k) % N] > 0) return (last + k) % N;
        end
        return -1;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst_n) begin
            check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
            check(src_rd == '0, "R1", "src_rd in reset", int'(src_rd), 0);
        end else begin
            check($countones(src_rd) <= 1, "R2", "read enables high", $countones(src_rd), 1);
            for (int s = 0; s < N; s++) begin
                if (src_rd[s]) check(pending[s] > 0, "R3", "read to source without record", s, -1);
            end
            if (out_valid) begin
                if (out_sop) begin
                    int srec, ex;
                    srec = int'(out_data[15:8]);
                    check(!in_rec, "R4", "start inside open record", int'(in_rec), 0);
                    check(srec < N && pending[srec % N] > 0, "R3", "record from source without record", srec, -1);
                    if (fresh) begin
                        check(srec == 0, "R1", "first source after reset", srec, 0);
                        fresh = 0;
                    end else if (chain) begin
                        ex = rr_next(last_served);
                        check(srec == ex, "R7", "round-robin next source", srec, ex);
                        check(cyc - eop_cyc == ((ex - last_served - 1 + N) % N) + 2, "R8",
                              "eop-to-sop gap", cyc - eop_cyc, ((ex - last_served - 1 + N) % N) + 2);
                    end else if (lat_armed) begin
                        check(cyc - inject_cyc >= 2 && cyc - inject_cyc <= N + 1, "R8",
                              "idle latency", cyc - inject_cyc, N + 1);
                    end
                    lat_armed = 0;
                    in_rec = 1;
                    cur_src = srec;
                    exp_idx = 0;
                end
                check(in_rec, "R6", "valid word outside a record", int'(in_rec), 1);
                check(out_data == {8'(cur_src), 8'(exp_idx)}, "R5", "output word",
                      int'(out_data), int'({8'(cur_src), 8'(exp_idx)}));
                check(out_sop == (exp_idx == 0), "R6", "sop position", int'(out_sop), int'(exp_idx == 0));
                check(out_eop == (exp_idx == L - 1), "R6", "eop position", int'(out_eop), int'(exp_idx == L - 1));
                if (out_eop) begin
                    bit others;
                    others = pending[cur_src] > 1;
                    for (int s = 0; s < N; s++) if (s != cur_src && pending[s] > 0) others = 1;
                    in_rec = 0;
                    last_served = cur_src;
                    eop_cyc = cyc;
                    chain = others;
                    served_total++;
                end
                exp_idx++;
            end else if (in_rec) begin
                check(0, "R4", "gap inside record at word", exp_idx, -1);
                in_rec = 0;
            end
            // Source model: consume the word read in the previous cycle
            for (int s = 0; s < N; s++) begin
                if (rd_prev[s]) begin
                    widx[s]++;
                    if (widx[s] == L) begin
                        widx[s] = 0;
                        pending[s]--;
                    end
                end
            end
            rd_prev = src_rd;
        end
    end

    function automatic bit all_idle();
        for (int s = 0; s < N; s++) if (pending[s] > 0) return 0;
        return !in_rec && !out_valid;
    endfunction

    task automatic inject(input logic [N-1:0] mask, input int n);
        @(posedge clk);
        #1;
        if (all_idle()) begin
            inject_cyc = cyc;
            lat_armed = 1;
        end
        for (int s = 0; s < N; s++) begin
            if (mask[s]) begin
                pending[s] += n;
                injected_total += n;
            end
        end
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!all_idle()) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_sop();
        @(negedge clk);
        while (!out_sop) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        rd_prev = '0;
        for (int s = 0; s < N; s++) begin
            pending[s] = 0;
            widx[s] = 0;
            hide[s] = 0;
        end
        // R1/R7: every source holds a record when reset is released
        for (int s = 0; s < N; s++) pending[s] = 1;
        injected_total = N;
        fresh = 1;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid first cycle after reset", int'(out_valid), 0);
        check(src_rd == '0, "R1", "src_rd first cycle after reset", int'(src_rd), 0);
        wait_idle();

        // R8: lone source, swept over every index with varied idle spacing
        for (int s = 0; s < N; s++) begin
            repeat ((s * 3) % 7) @(posedge clk);
            inject(N'(1) << s, 1);
            wait_idle();
        end

        // R7: sparse ready set with a repeated source
        inject(N'(1) << 3 | N'(1) << 5 | N'(1) << 9, 1);
        pending[3] += 1;
        injected_total += 1;
        wait_idle();

        // R9: granted source drops its flag mid-record
        inject(N'(1) << 6, 1);
        wait_sop();
        hide[6] = 1;
        repeat (3) @(negedge clk);
        hide[6] = 0;
        wait_idle();

        // R7/R9: new records arrive during a drain
        inject(N'(1) << 2, 1);
        wait_sop();
        inject(N'(1) << 1 | N'(1) << 4, 1);
        wait_idle();

        // R7: wrap from last source to first with all busy again
        inject({N{1'b1}}, 2);
        wait_idle();

        check(served_total == injected_total, "R4", "records out vs offered", served_total, injected_total);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule